// File: doc/BRIEF.md
# I2C EEPROM Reset-Configuration Loader

This block runs while the chip is still held in reset. It fetches two 32-bit configuration words from a serial EEPROM by driving a byte-level I2C master command interface. That interface carries start, stop, byte write and byte read commands, with a per-read ACK/NACK choice. The loader checks a three-byte signature and two address-tagged records. Only when every check passes does it latch both words and drop its reset hold. After that it raises a boot-sequencer enable when a two-bit field of the high word holds the value 2'b10.

The bit-level bus engine sits outside this block. It accepts one command at a time and reports completion with a one-cycle `i2c_cmd_done` pulse. With that pulse it returns the slave's acknowledge for writes and the received byte for reads. The loader is the only master on the bus while it is active.

On any failure the loader sets a sticky error flag, keeps the reset hold asserted and never updates the configuration words. Failures are a missing acknowledge, a wrong signature or a record whose register offset does not match.

Top module: `rcw_loader`

## Requirements
- R1: While `rst_n` is low, `hold_reset` is 1, `load_done`, `load_err` and `boot_seq_en` are 0, both words are 0 and `i2c_cmd_valid` is 0.
- R2: Command codes are START=0, STOP=1, WRITE=2, READ=3. A clean load issues exactly 24 commands in this order: START, WRITE 0xA0, WRITE 0x00, WRITE 0x00, START, WRITE 0xA1, then 17 READs, then STOP. `i2c_cmd_nack` is 1 only on the last READ.
- R3: `i2c_cmd_valid` is high for single cycles only, and no new command is issued before the previous one's `i2c_cmd_done`.
- R4: Read bytes 0..2 must be 0xAA, 0x55, 0xAA. Any mismatch sets `load_err` and no words are latched.
- R5: Bytes 4..5 form a big-endian offset that must equal 0x0100. Bytes 11..12 form a big-endian offset that must equal 0x0104. A mismatch sets `load_err`.
- R6: The low word is read bytes 6..9 and the high word is read bytes 13..16, each taken most significant byte first.
- R7: When all checks pass, both words appear on `rcw_lo`/`rcw_hi` together with `load_done`=1 and `hold_reset`=0, within a few cycles of the STOP completing.
- R8: A WRITE answered with `i2c_rsp_ack`=0 sets `load_err`. The very next command is STOP, and nothing else follows it.
- R9: `load_err` is sticky until reset. While it is set, `hold_reset` stays 1 and both words keep their reset value.
- R10: `boot_seq_en` is 1 only after a successful load whose high word has bits [23:22] equal to 2'b10.
- R11: Attribute bytes 3 and 10 may hold any value and have no effect on the outcome or the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| i2c_cmd_valid | output | 1 | One-cycle command issue strobe |
| i2c_cmd_op | output | 2 | Command code (START, STOP, WRITE, READ) |
| i2c_cmd_wdata | output | 8 | Byte to send for WRITE |
| i2c_cmd_nack | output | 1 | For READ: master answers with NACK |
| i2c_cmd_done | input | 1 | Command completion pulse |
| i2c_rsp_ack | input | 1 | Slave acknowledged the written byte |
| i2c_rsp_rdata | input | 8 | Byte received by READ |
| rcw_lo | output | 32 | Latched low configuration word |
| rcw_hi | output | 32 | Latched high configuration word |
| load_done | output | 1 | Load finished successfully |
| load_err | output | 1 | Sticky load failure |
| hold_reset | output | 1 | Keeps the chip in reset |
| boot_seq_en | output | 1 | Enables the functional boot sequencer |

## Verification
A byte-level EEPROM model answers commands with random latency. It is loaded with clean images whose words, attribute bytes and boot field vary. This separates correct byte ordering and field decoding from swapped or shifted assembly. Directed images corrupt each signature byte and each offset byte, and swap the two offsets, which tells record-position errors apart from value errors. Refused acknowledges on each of the four writes show whether the abort happens at the right command. Random images corrupt one critical byte or inject one refusal, exposing checks that are skipped or done on the wrong byte index.

// File: rtl/rcwl_pkg.sv
package rcwl_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } i2c_op_e;

   localparam int SIG_LEN    = 3;
   localparam int REC_HDR    = 3;
   localparam int WORD_BYTES = 4;
   localparam int WORD_W     = 8 * WORD_BYTES;
   localparam int REC_LEN    = REC_HDR + WORD_BYTES;
   localparam int NUM_REC    = 2;
   localparam int NUM_READ   = SIG_LEN + NUM_REC * REC_LEN;
   localparam int IDX_W      = $clog2(NUM_READ);

   function automatic logic [7:0] sig_byte(input int pos);
      return (pos % 2 == 1) ? 8'h55 : 8'hAA;
   endfunction

endpackage

// File: rtl/rcwl_seq.sv
module rcwl_seq
   import rcwl_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h50,
   parameter logic [15:0] MEM_ADDR = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             cmd_valid,
   output i2c_op_e          cmd_op,
   output logic [7:0]       cmd_wdata,
   output logic             cmd_nack,
   input  logic             cmd_done,
   input  logic             rsp_ack,
   input  logic [7:0]       rsp_rdata,
   output logic             byte_vld,
   output logic [IDX_W-1:0] byte_idx,
   output logic [7:0]       byte_val,
   output logic             ack_fail,
   output logic             seq_end
);

   localparam int N_STEPS = 7 + NUM_READ;
   localparam int STEP_W  = $clog2(N_STEPS);
   localparam logic [STEP_W-1:0] ST_ADW   = STEP_W'(1);
   localparam logic [STEP_W-1:0] ST_MHI   = STEP_W'(2);
   localparam logic [STEP_W-1:0] ST_MLO   = STEP_W'(3);
   localparam logic [STEP_W-1:0] ST_RSTRT = STEP_W'(4);
   localparam logic [STEP_W-1:0] ST_ADR   = STEP_W'(5);
   localparam logic [STEP_W-1:0] ST_RD0   = STEP_W'(6);
   localparam logic [STEP_W-1:0] ST_LAST  = STEP_W'(6 + NUM_READ - 1);
   localparam logic [STEP_W-1:0] ST_STOP  = STEP_W'(N_STEPS - 1);

   typedef enum logic [2:0] {SQ_BOOT, SQ_ISSUE, SQ_WAIT, SQ_END, SQ_PARK} sq_state_e;

   sq_state_e         state_q;
   logic [STEP_W-1:0] step_q;

   always_comb begin
      cmd_op    = OP_READ;
      cmd_wdata = '0;
      cmd_nack  = 1'b0;
      if (step_q == '0 || step_q == ST_RSTRT) begin
         cmd_op = OP_START;
      end else if (step_q == ST_ADW) begin
         cmd_op    = OP_WRITE;
         cmd_wdata = {DEV_ADDR, 1'b0};
      end else if (step_q == ST_MHI) begin
         cmd_op    = OP_WRITE;
         cmd_wdata = MEM_ADDR[15:8];
      end else if (step_q == ST_MLO) begin
         cmd_op    = OP_WRITE;
         cmd_wdata = MEM_ADDR[7:0];
      end else if (step_q == ST_ADR) begin
         cmd_op    = OP_WRITE;
         cmd_wdata = {DEV_ADDR, 1'b1};
      end else if (step_q == ST_STOP) begin
         cmd_op = OP_STOP;
      end else begin
         cmd_op   = OP_READ;
         cmd_nack = (step_q == ST_LAST);
      end
   end

   logic fin;
   assign cmd_valid = (state_q == SQ_ISSUE);
   assign fin       = (state_q == SQ_WAIT) && cmd_done;
   assign ack_fail  = fin && (cmd_op == OP_WRITE) && !rsp_ack;
   assign byte_vld  = fin && (cmd_op == OP_READ);
   assign byte_idx  = IDX_W'(step_q - ST_RD0);
   assign byte_val  = rsp_rdata;
   assign seq_end   = (state_q == SQ_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_BOOT;
         step_q  <= '0;
      end else begin
         case (state_q)
            SQ_BOOT:  state_q <= SQ_ISSUE;
            SQ_ISSUE: state_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (fin) begin
                  state_q <= SQ_ISSUE;
                  if (ack_fail) begin
                     step_q <= ST_STOP;
                  end else if (step_q == ST_STOP) begin
                     state_q <= SQ_END;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            SQ_END:   state_q <= SQ_PARK;
            default:  state_q <= SQ_PARK;
         endcase
      end
   end

   // R3: an issue strobe never lasts two cycles
   assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R3: a new command waits for the completion pulse
   assert_wait_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_WAIT && !cmd_done) |=> !cmd_valid);

   // R8: a refused write is followed directly by STOP
   assert_stop_after_refusal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fail |=> (cmd_valid && cmd_op == OP_STOP));

endmodule

// File: rtl/rcwl_parse.sv
module rcwl_parse
   import rcwl_pkg::*;
#(
   parameter logic [15:0] OFS_LO = 16'h0100,
   parameter logic [15:0] OFS_HI = 16'h0104
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [7:0]        byte_val,
   output logic [WORD_W-1:0] word_lo,
   output logic [WORD_W-1:0] word_hi,
   output logic              parse_bad
);

   localparam logic [IDX_W-1:0] SIG_END = IDX_W'(SIG_LEN);

   logic                              sig_bad_q;
   logic [NUM_REC-1:0]                rec_bad;
   logic [NUM_REC-1:0][WORD_W-1:0]    words;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_bad_q <= 1'b0;
      end else if (byte_vld && byte_idx < SIG_END &&
                   byte_val != sig_byte(int'(byte_idx))) begin
         sig_bad_q <= 1'b1;
      end
   end

   for (genvar r = 0; r < NUM_REC; r++) begin : g_rec
      localparam int              BASE = SIG_LEN + r * REC_LEN;
      localparam logic [15:0]     EXP  = (r == 0) ? OFS_LO : OFS_HI;
      localparam logic [IDX_W-1:0] I_OH = IDX_W'(BASE + 1);
      localparam logic [IDX_W-1:0] I_OL = IDX_W'(BASE + 2);
      localparam logic [IDX_W-1:0] I_W0 = IDX_W'(BASE + REC_HDR);
      localparam logic [IDX_W-1:0] I_WN = IDX_W'(BASE + REC_LEN);

      logic              bad_q;
      logic [WORD_W-1:0] wq;
      logic              take;

      assign take = byte_vld && !sig_bad_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bad_q <= 1'b0;
            wq    <= '0;
         end else if (take) begin
            if ((byte_idx == I_OH && byte_val != EXP[15:8]) ||
                (byte_idx == I_OL && byte_val != EXP[7:0])) begin
               bad_q <= 1'b1;
            end
            if (byte_idx >= I_W0 && byte_idx < I_WN) begin
               wq <= {wq[WORD_W-9:0], byte_val};
            end
         end
      end

      assign rec_bad[r] = bad_q;
      assign words[r]   = wq;
   end

   assign word_lo   = words[0];
   assign word_hi   = words[NUM_REC-1];
   assign parse_bad = sig_bad_q | (|rec_bad);

   // R2: the sequencer never delivers more bytes than the image holds
   assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> (int'(byte_idx) < NUM_READ));

   // R4: a flagged signature freezes the assembled words
   assert_sig_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sig_bad_q |=> ($stable(word_lo) && $stable(word_hi)));

endmodule

// File: rtl/rcw_loader.sv
module rcw_loader
   import rcwl_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR  = 7'h50,
   parameter logic [15:0] MEM_ADDR  = 16'h0000,
   parameter logic [15:0] OFS_LO    = 16'h0100,
   parameter logic [15:0] OFS_HI    = 16'h0104,
   parameter int          BSEQ_MSB  = 23,
   parameter int          BSEQ_LSB  = 22
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        i2c_cmd_valid,
   output logic [1:0]  i2c_cmd_op,
   output logic [7:0]  i2c_cmd_wdata,
   output logic        i2c_cmd_nack,
   input  logic        i2c_cmd_done,
   input  logic        i2c_rsp_ack,
   input  logic [7:0]  i2c_rsp_rdata,
   output logic [31:0] rcw_lo,
   output logic [31:0] rcw_hi,
   output logic        load_done,
   output logic        load_err,
   output logic        hold_reset,
   output logic        boot_seq_en
);

   if (BSEQ_MSB != BSEQ_LSB + 1) begin : g_bad_field
      $error("boot field must be two adjacent bits");
   end
   if (BSEQ_MSB >= WORD_W || BSEQ_LSB < 0) begin : g_bad_range
      $error("boot field outside the word");
   end
   if (OFS_LO == OFS_HI) begin : g_bad_ofs
      $error("record offsets must differ");
   end

   i2c_op_e             seq_op;
   logic                byte_vld;
   logic [IDX_W-1:0]    byte_idx;
   logic [7:0]          byte_val;
   logic                ack_fail;
   logic                seq_end;
   logic                parse_bad;
   logic [WORD_W-1:0]   word_lo;
   logic [WORD_W-1:0]   word_hi;

   rcwl_seq #(.DEV_ADDR(DEV_ADDR), .MEM_ADDR(MEM_ADDR)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (i2c_cmd_valid),
      .cmd_op    (seq_op),
      .cmd_wdata (i2c_cmd_wdata),
      .cmd_nack  (i2c_cmd_nack),
      .cmd_done  (i2c_cmd_done),
      .rsp_ack   (i2c_rsp_ack),
      .rsp_rdata (i2c_rsp_rdata),
      .byte_vld  (byte_vld),
      .byte_idx  (byte_idx),
      .byte_val  (byte_val),
      .ack_fail  (ack_fail),
      .seq_end   (seq_end)
   );

   rcwl_parse #(.OFS_LO(OFS_LO), .OFS_HI(OFS_HI)) u_parse (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .byte_idx  (byte_idx),
      .byte_val  (byte_val),
      .word_lo   (word_lo),
      .word_hi   (word_hi),
      .parse_bad (parse_bad)
   );

   assign i2c_cmd_op = seq_op;

   logic err_q, done_q, hold_q, bseq_q, commit;
   logic [WORD_W-1:0] lo_q, hi_q;

   assign commit = seq_end && !err_q && !parse_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         done_q <= 1'b0;
         hold_q <= 1'b1;
         bseq_q <= 1'b0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         if (ack_fail || parse_bad) begin
            err_q <= 1'b1;
         end
         if (commit) begin
            lo_q   <= word_lo;
            hi_q   <= word_hi;
            done_q <= 1'b1;
            hold_q <= 1'b0;
            bseq_q <= (word_hi[BSEQ_MSB:BSEQ_LSB] == 2'b10);
         end
      end
   end

   assign rcw_lo      = lo_q;
   assign rcw_hi      = hi_q;
   assign load_done   = done_q;
   assign load_err    = err_q;
   assign hold_reset  = hold_q;
   assign boot_seq_en = bseq_q;

   // R9: the error flag never clears without reset
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> load_err);

   // R9: after an outcome the words never move
   assert_words_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_err || load_done) |=> ($stable(rcw_lo) && $stable(rcw_hi)));

   // R9: an error keeps the chip in reset
   assert_hold_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> hold_reset);

   // R7: release only comes with a clean completion
   assert_release_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_reset) |-> (load_done && !load_err));

   // R10: the boot enable never precedes release
   assert_boot_after_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      boot_seq_en |-> !hold_reset);

endmodule

// File: tb/test_rcw_loader.sv
module test_rcw_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i2c_cmd_valid;
   logic [1:0]  i2c_cmd_op;
   logic [7:0]  i2c_cmd_wdata;
   logic        i2c_cmd_nack;
   logic        i2c_cmd_done = 1'b0;
   logic        i2c_rsp_ack = 1'b0;
   logic [7:0]  i2c_rsp_rdata = 8'h00;
   logic [31:0] rcw_lo, rcw_hi;
   logic        load_done, load_err, hold_reset, boot_seq_en;

   rcw_loader i_rcw_loader (
      .clk(clk), .rst_n(rst_n),
      .i2c_cmd_valid(i2c_cmd_valid), .i2c_cmd_op(i2c_cmd_op),
      .i2c_cmd_wdata(i2c_cmd_wdata), .i2c_cmd_nack(i2c_cmd_nack),
      .i2c_cmd_done(i2c_cmd_done), .i2c_rsp_ack(i2c_rsp_ack),
      .i2c_rsp_rdata(i2c_rsp_rdata),
      .rcw_lo(rcw_lo), .rcw_hi(rcw_hi), .load_done(load_done),
      .load_err(load_err), .hold_reset(hold_reset), .boot_seq_en(boot_seq_en)
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [7:0] img [17];
   int nack_at = -1;

   int   log_n;
   int   log_op [64];
   int   log_dat [64];
   bit   log_nk [64];
   int   r3_viol;
   bit   stop_seen;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // EEPROM and bus engine model, evaluated on falling edges
   initial begin
      bit busy = 0;
      int cnt = 0;
      int p_op = 0;
      int p_dat = 0;
      int phase = 0;
      int ptr = 0;
      int wr_cnt = 0;
      forever begin
         @(negedge clk);
         i2c_cmd_done = 1'b0;
         if (!rst_n) begin
            busy = 0; phase = 0; ptr = 0; wr_cnt = 0;
         end else begin
            if (busy && i2c_cmd_valid) r3_viol++;
            if (busy) begin
               if (cnt == 0) begin
                  busy = 0;
                  i2c_cmd_done = 1'b1;
                  case (p_op)
                     0: phase = 0;
                     2: begin
                        if (phase == 0) begin
                           i2c_rsp_ack = (p_dat[7:1] == 7'h50);
                           phase = 1;
                        end else if (phase == 1) begin
                           ptr = (ptr & 255) | (p_dat << 8);
                           i2c_rsp_ack = 1'b1; phase = 2;
                        end else begin
                           ptr = (ptr & 32'hFF00) | p_dat;
                           i2c_rsp_ack = 1'b1; phase = 3;
                        end
                        if (wr_cnt == nack_at) i2c_rsp_ack = 1'b0;
                        wr_cnt++;
                     end
                     3: begin
                        i2c_rsp_rdata = (ptr < 17) ? img[ptr] : 8'hFF;
                        ptr++;
                     end
                     default: phase = 0;
                  endcase
               end else begin
                  cnt--;
               end
            end else if (i2c_cmd_valid) begin
               if (log_n < 64) begin
                  log_op[log_n]  = int'(i2c_cmd_op);
                  log_dat[log_n] = int'(i2c_cmd_wdata);
                  log_nk[log_n]  = i2c_cmd_nack;
               end
               log_n++;
               if (i2c_cmd_op == 2'd1) stop_seen = 1'b1;
               p_op  = int'(i2c_cmd_op);
               p_dat = int'(i2c_cmd_wdata);
               cnt   = $urandom_range(0, 2);
               busy  = 1;
            end
         end
      end
   end

   function automatic void exp_cmd(input int i, output int op, output int dat, output bit nk);
      op = 3; dat = 0; nk = 0;
      if (i == 0 || i == 4) op = 0;
      else if (i == 1) begin op = 2; dat = 8'hA0; end
      else if (i == 2 || i == 3) begin op = 2; dat = 0; end
      else if (i == 5) begin op = 2; dat = 8'hA1; end
      else if (i == 23) op = 1;
      else nk = (i == 22);
   endfunction

   function automatic bit image_ok();
      return img[0] == 8'hAA && img[1] == 8'h55 && img[2] == 8'hAA &&
             {img[4], img[5]} == 16'h0100 && {img[11], img[12]} == 16'h0104;
   endfunction

   task automatic build(input logic [31:0] lo, input logic [31:0] hi,
                        input logic [7:0] a0, input logic [7:0] a1);
      img[0] = 8'hAA; img[1] = 8'h55; img[2] = 8'hAA;
      img[3] = a0; img[4] = 8'h01; img[5] = 8'h00;
      for (int b = 0; b < 4; b++) img[6 + b] = lo[31 - 8*b -: 8];
      img[10] = a1; img[11] = 8'h01; img[12] = 8'h04;
      for (int b = 0; b < 4; b++) img[13 + b] = hi[31 - 8*b -: 8];
   endtask

   task automatic run_trial(input string name, input int nk);
      bit ok;
      logic [31:0] e_lo, e_hi;
      int waited;
      nack_at = nk;
      rst_n = 1'b0;
      log_n = 0; r3_viol = 0; stop_seen = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(hold_reset == 1'b1 && load_done == 1'b0 && load_err == 1'b0 &&
          boot_seq_en == 1'b0 && i2c_cmd_valid == 1'b0, "R1", {name, " flags"},
          {27'd0, hold_reset, load_done, load_err, boot_seq_en, i2c_cmd_valid}, 32'h10);
      chk(rcw_lo == 0 && rcw_hi == 0, "R1", {name, " words"}, rcw_lo | rcw_hi, 0);
      rst_n = 1'b1;
      waited = 0;
      while (!stop_seen && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      chk(stop_seen, "R2", {name, " stop reached"}, 32'(stop_seen), 1);
      repeat (6) @(negedge clk);

      ok   = image_ok() && nk < 0;
      e_lo = {img[6], img[7], img[8], img[9]};
      e_hi = {img[13], img[14], img[15], img[16]};
      chk(r3_viol == 0, "R3", {name, " overlap"}, r3_viol, 0);
      chk(load_err == !ok, "R4 R5 R8 R9", {name, " err"}, 32'(load_err), 32'(!ok));
      chk(load_done == ok && hold_reset == !ok, "R7 R9", {name, " done/hold"},
          {30'd0, load_done, hold_reset}, {30'd0, ok, !ok});
      chk(rcw_lo == (ok ? e_lo : 32'd0), "R6 R9 R11", {name, " lo"}, rcw_lo, ok ? e_lo : 32'd0);
      chk(rcw_hi == (ok ? e_hi : 32'd0), "R6 R9 R11", {name, " hi"}, rcw_hi, ok ? e_hi : 32'd0);
      chk(boot_seq_en == (ok && e_hi[23:22] == 2'b10), "R10", {name, " boot"},
          32'(boot_seq_en), 32'(ok && e_hi[23:22] == 2'b10));

      if (nk < 0) begin
         int mism = 0;
         for (int i = 0; i < 24; i++) begin
            int op, dat; bit n;
            exp_cmd(i, op, dat, n);
            if (log_op[i] != op || (op == 2 && log_dat[i] != dat) ||
                (op == 3 && log_nk[i] != n)) mism++;
         end
         chk(log_n == 24 && mism == 0, "R2", {name, " command order"}, log_n * 256 + mism, 24 * 256);
      end else begin
         int last_step = (nk < 3) ? nk + 1 : 5;
         int reads = 0;
         for (int i = 0; i < log_n && i < 64; i++) if (log_op[i] == 3) reads++;
         chk(log_n == last_step + 2 && log_op[(log_n - 1) & 63] == 1 && reads == 0,
             "R8", {name, " abort"}, log_n, last_step + 2);
      end
   endtask

   initial begin
      logic [31:0] lo, hi;
      void'($urandom(32'h1C0DE));
      for (int i = 0; i < 17; i++) img[i] = 8'h00;
      // R6 R7 R10: clean loads with varied boot field
      build(32'h12345678, 32'h00800001, 8'h00, 8'h00); run_trial("good_boot10", -1);
      build(32'hDEADBEEF, 32'h00C0FFEE, 8'h11, 8'h22); run_trial("good_boot11", -1);
      build(32'h0, 32'h00400000, 8'h5A, 8'hA5);        run_trial("good_boot01", -1);
      // R11: extreme attribute bytes
      build(32'hCAFEF00D, 32'hFFBFFFFF, 8'hFF, 8'hFF); run_trial("attr_ff", -1);
      // R4: signature corruption
      build(32'h11111111, 32'h00800000, 8'h00, 8'h00); img[0] = 8'hAB; run_trial("sig0", -1);
      build(32'h11111111, 32'h00800000, 8'h00, 8'h00); img[1] = 8'hAA; run_trial("sig1", -1);
      build(32'h11111111, 32'h00800000, 8'h00, 8'h00); img[2] = 8'h55; run_trial("sig2", -1);
      // R5: offset corruption and swap
      build(32'h22222222, 32'h00800000, 8'h00, 8'h00); img[4] = 8'h02; run_trial("ofs_lo_hi", -1);
      build(32'h22222222, 32'h00800000, 8'h00, 8'h00); img[12] = 8'h00; run_trial("ofs_hi_lo", -1);
      build(32'h22222222, 32'h00800000, 8'h00, 8'h00); img[5] = 8'h04; img[12] = 8'h00;
      run_trial("ofs_swap", -1);
      // R8: refused acknowledge on each write
      for (int w = 0; w < 4; w++) begin
         build(32'h33333333, 32'h00800000, 8'h00, 8'h00);
         run_trial($sformatf("nack_w%0d", w), w);
      end
      // random images with occasional damage
      for (int t = 0; t < 30; t++) begin
         int pick, nk;
         int crit [7] = '{0, 1, 2, 4, 5, 11, 12};
         lo = $urandom; hi = $urandom;
         build(lo, hi, 8'($urandom), 8'($urandom));
         pick = $urandom_range(0, 5);
         nk = -1;
         if (pick < 2) img[crit[$urandom_range(0, 6)]] ^= 8'($urandom_range(1, 255));
         else if (pick == 2) nk = $urandom_range(0, 3);
         run_trial($sformatf("rand%0d", t), nk);
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule